// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block sits in front of an asynchronous DRAM access controller and owns two jobs: bringing the memory out of power-up and keeping its rows refreshed. After reset it holds RAS high for a start-up pause of 200 us, measured in clock cycles. It then runs a fixed number of wake-up cycles on the DRAM strobes. Once those are done it raises `ready` and keeps up a refresh rate of 1,024 rows per 16 ms.

Refresh runs in one of two styles, chosen by `rao_mode`. With `rao_mode` low, the block drives the strobes itself. Each refresh is a CAS-before-RAS cycle, and the DRAM's own counter picks the row. With `rao_mode` high, the block raises `ref_req` and presents a row on `ref_row`. The access controller then runs a RAS-only cycle for that row and answers with `grant`. Refreshes that cannot be served at once are counted up to a limit and are issued back to back later. If that limit is exceeded, the block raises a sticky error flag and reruns the wake-up sequence. `pin_own` tells the pin multiplexer when the strobes of this block must reach the DRAM.

Top module: `rfsh_sequencer`

## Requirements
- R1: After reset, `ras_n` stays high for at least CLK_KHZ/5 clock cycles, which is the 200 us start-up pause.
- R2: After the pause, exactly WAKE_CYCLES falling edges of `ras_n` occur before `ready` rises. `ready` is low until then, and `ref_req` is never high while `ready` is low.
- R3: Every cycle the block drives on its strobes is a CAS-before-RAS cycle. The `cas_n` strobes selected by CAS_MASK go low T_CAS_SETUP cycles before `ras_n` falls, with `ras_n` still high. They stay low for T_CAS_HOLD cycles after the fall. `ras_n` stays low for T_CAS_HOLD+T_RAS_TAIL cycles in total. Bit 0 of `cas_n` is the lower-byte strobe and bit 1 the upper-byte strobe.
- R4: With `rao_mode` low and `ready` high, one refresh is issued every CLK_KHZ/64 cycles, which is 16 ms divided by 1,024. In this mode `ref_req` stays low and `grant` has no effect.
- R5: With `rao_mode` high and `ready` high, a due refresh raises `ref_req`. While `ref_req` is high, `pin_own` is low and all strobes are high. `ref_row` holds its value while `grant` is low.
- R6: Each cycle with both `ref_req` and `grant` high completes one refresh and advances `ref_row` by one. The row runs modulo 2^ROW_W, so it goes from 1023 to 0 with the default width.
- R7: Refreshes that fall due without service are counted, up to BACKLOG_MAX of them. When `grant` is held high they are served on consecutive cycles.
- R8: If a refresh falls due while BACKLOG_MAX refreshes are already waiting, the block does the following:
  - it sets `err`, which stays high until reset;
  - it drops `ready` on the same edge;
  - it reruns the WAKE_CYCLES wake-up cycles and then raises `ready` again.
  The row counter keeps its value through this.
- R9: During reset, the outputs are as follows: `ready`=0, `err`=0, `ref_req`=0, `ref_row`=0, `pin_own`=1, `ras_n`=1 and all `cas_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rao_mode | input | 1 | 1: row-address refresh through request/grant; 0: CAS-before-RAS on own strobes |
| grant | input | 1 | Controller has issued the requested row refresh this cycle |
| ready | output | 1 | Memory initialised and refresh running |
| err | output | 1 | Sticky: refresh backlog overflowed |
| ref_req | output | 1 | A row refresh is due (row-address style) |
| ref_row | output | ROW_W | Row to refresh when `ref_req` is high |
| pin_own | output | 1 | Strobes below must be routed to the DRAM |
| ras_n | output | 1 | Row strobe drive, active low |
| cas_n | output | NUM_CAS | Column strobe drives, active low, bit 0 lower byte |

## Verification
The bench first measures the start-up pause and counts the wake-up cycles. A sequencer that started early, or counted its wake-up cycles one short or one long, would put the first RAS fall inside the pause or raise `ready` with the wrong number of RAS falls. The strobe shape of every CAS-before-RAS cycle is timed edge to edge, which catches a CAS that rises before its hold time or a RAS pulse of the wrong width. In the row-address style, a scoreboard follows more than a thousand grants, across the 1023-to-0 wrap. It then withholds grants for exactly two intervals and expects a burst of exactly two back-to-back grants. A lost or duplicated backlog entry would change the burst length or skip a row. Finally, starving the handshake must raise `err` while `ready` drops, followed by exactly one rerun of the wake-up sequence.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    SEQ_PAUSE = 2'd0,
    SEQ_WAKE  = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_HOLD  = 3'd2,
    PH_TAIL  = 3'd3,
    PH_PRE   = 3'd4
  } cbr_phase_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
  parameter int unsigned PERIOD = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int unsigned MAX_PEND = 4,
  localparam int unsigned PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] level,
  output logic [PW-1:0] level_nxt,
  output logic          full
);
  localparam logic [PW-1:0] TOP = PW'(MAX_PEND);

  logic [PW-1:0] lvl_q;

  always_comb begin
    level_nxt = lvl_q;
    if (clr) begin
      level_nxt = '0;
    end else if (inc && !dec && (lvl_q != TOP)) begin
      level_nxt = lvl_q + 1'b1;
    end else if (dec && !inc && (lvl_q != '0)) begin
      level_nxt = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= level_nxt;
  end

  assign level = lvl_q;
  assign full  = (lvl_q == TOP);

endmodule

// File: rtl/rfsh_cbr_gen.sv
module rfsh_cbr_gen
  import rfsh_pkg::*;
#(
  parameter int unsigned NUM_CAS  = 2,
  parameter logic [NUM_CAS-1:0] CAS_MASK = '1,
  parameter int unsigned T_SETUP  = 1,
  parameter int unsigned T_HOLD   = 1,
  parameter int unsigned T_TAIL   = 4,
  parameter int unsigned T_PRE    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               ras_n,
  output logic [NUM_CAS-1:0] cas_n
);
  localparam int unsigned TMAX = max2(max2(T_SETUP, T_HOLD), max2(T_TAIL, T_PRE));
  localparam int unsigned CW   = $clog2(TMAX + 1);

  cbr_phase_t ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic ras_n_q, done_q, cas_low_d;
  logic [NUM_CAS-1:0] cas_n_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d  = PH_SETUP;
        cnt_d = CW'(T_SETUP - 1);
      end
      PH_SETUP: if (cnt_q == '0) begin
        ph_d  = PH_HOLD;
        cnt_d = CW'(T_HOLD - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_q == '0) begin
        ph_d  = PH_TAIL;
        cnt_d = CW'(T_TAIL - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_TAIL: if (cnt_q == '0) begin
        ph_d  = PH_PRE;
        cnt_d = CW'(T_PRE - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_PRE: if (cnt_q == '0) begin
        ph_d  = PH_IDLE;
      end else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign cas_low_d = (ph_d == PH_SETUP) || (ph_d == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      ras_n_q <= !((ph_d == PH_HOLD) || (ph_d == PH_TAIL));
      done_q  <= (ph_q == PH_PRE) && (cnt_q == '0);
    end
  end

  for (genvar i = 0; i < NUM_CAS; i++) begin : g_cas
    if (CAS_MASK[i]) begin : g_on
      always_ff @(posedge clk) begin
        if (rst) cas_n_q[i] <= 1'b1;
        else     cas_n_q[i] <= !cas_low_d;
      end
    end else begin : g_off
      always_ff @(posedge clk) cas_n_q[i] <= 1'b1;
    end
  end

  assign busy  = (ph_q != PH_IDLE);
  assign done  = done_q;
  assign ras_n = ras_n_q;
  assign cas_n = cas_n_q;

endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 100000,
  parameter int unsigned WAKE_CYCLES = 8,
  parameter int unsigned BACKLOG_MAX = 4,
  parameter int unsigned ROW_W       = 10,
  parameter int unsigned NUM_CAS     = 2,
  parameter logic [NUM_CAS-1:0] CAS_MASK = '1,
  parameter int unsigned T_CAS_SETUP = 1,
  parameter int unsigned T_CAS_HOLD  = 1,
  parameter int unsigned T_RAS_TAIL  = 4,
  parameter int unsigned T_RAS_PRE   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rao_mode,
  input  logic               grant,
  output logic               ready,
  output logic               err,
  output logic               ref_req,
  output logic [ROW_W-1:0]   ref_row,
  output logic               pin_own,
  output logic               ras_n,
  output logic [NUM_CAS-1:0] cas_n
);
  // 200 us = CLK_KHZ/5 cycles; 16 ms / 1024 = CLK_KHZ/64 cycles
  localparam int unsigned STARTUP_CYC      = CLK_KHZ / 5;
  localparam int unsigned REF_INTERVAL_CYC = CLK_KHZ / 64;
  localparam int unsigned PA_W = $clog2(STARTUP_CYC);
  localparam int unsigned WK_W = $clog2(WAKE_CYCLES + 1);
  localparam int unsigned PW   = $clog2(BACKLOG_MAX + 1);
  localparam logic [PA_W-1:0] PA_LAST = PA_W'(STARTUP_CYC - 1);
  localparam logic [WK_W-1:0] WK_ALL  = WK_W'(WAKE_CYCLES);

  seq_state_t st_q, st_d;
  logic [PA_W-1:0]  pa_q;
  logic [WK_W-1:0]  wk_q;
  logic [ROW_W-1:0] row_q;
  logic ref_req_q, ref_req_d, ready_q, err_q;

  logic run, serve, ovf, tick;
  logic gen_start, gen_busy, gen_done;
  logic bl_clr, bl_inc, bl_dec, bl_full;
  logic [PW-1:0] bl_lvl, bl_nxt, lvl_left;

  rfsh_tick #(.PERIOD(REF_INTERVAL_CYC)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (run),
    .tick(tick)
  );

  rfsh_backlog #(.MAX_PEND(BACKLOG_MAX)) u_backlog (
    .clk      (clk),
    .rst      (rst),
    .clr      (bl_clr),
    .inc      (bl_inc),
    .dec      (bl_dec),
    .level    (bl_lvl),
    .level_nxt(bl_nxt),
    .full     (bl_full)
  );

  rfsh_cbr_gen #(
    .NUM_CAS (NUM_CAS),
    .CAS_MASK(CAS_MASK),
    .T_SETUP (T_CAS_SETUP),
    .T_HOLD  (T_CAS_HOLD),
    .T_TAIL  (T_RAS_TAIL),
    .T_PRE   (T_RAS_PRE)
  ) u_cbr (
    .clk  (clk),
    .rst  (rst),
    .start(gen_start),
    .busy (gen_busy),
    .done (gen_done),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );

  always_comb begin
    run      = (st_q == SEQ_RUN);
    serve    = ref_req_q && grant;
    bl_dec   = serve || (run && gen_done);
    ovf      = run && tick && bl_full && !bl_dec;
    lvl_left = bl_lvl - PW'(bl_dec);
    bl_clr   = !run || ovf;
    bl_inc   = run && tick;
    gen_start = 1'b0;
    st_d      = st_q;
    unique case (st_q)
      SEQ_PAUSE: if (pa_q == PA_LAST) st_d = SEQ_WAKE;
      SEQ_WAKE: begin
        gen_start = !gen_busy && (wk_q != WK_ALL);
        if (gen_done && (wk_q == WK_ALL)) st_d = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (ovf) st_d = SEQ_WAKE;
        else     gen_start = !rao_mode && !gen_busy && (lvl_left != '0);
      end
      default: st_d = SEQ_PAUSE;
    endcase
    ref_req_d = (st_d == SEQ_RUN) && rao_mode && (bl_nxt != '0) &&
                !gen_busy && !gen_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SEQ_PAUSE;
      pa_q      <= '0;
      wk_q      <= '0;
      row_q     <= '0;
      ref_req_q <= 1'b0;
      ready_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      pa_q <= (st_q == SEQ_PAUSE) ? pa_q + 1'b1 : '0;
      if ((st_d == SEQ_WAKE) && (st_q != SEQ_WAKE)) wk_q <= '0;
      else if ((st_q == SEQ_WAKE) && gen_start)     wk_q <= wk_q + 1'b1;
      if (serve) row_q <= row_q + 1'b1;
      ref_req_q <= ref_req_d;
      ready_q   <= (st_d == SEQ_RUN);
      if (ovf) err_q <= 1'b1;
    end
  end

  assign ready   = ready_q;
  assign err     = err_q;
  assign ref_req = ref_req_q;
  assign ref_row = row_q;
  assign pin_own = !run || gen_busy;

endmodule

// File: rtl/rfsh_sequencer_chk.sv
module rfsh_sequencer_chk #(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned ROW_W   = 10,
  parameter int unsigned NUM_CAS = 2,
  parameter logic [NUM_CAS-1:0] CAS_MASK = '1
) (
  input logic               clk,
  input logic               rst,
  input logic               grant,
  input logic               ready,
  input logic               err,
  input logic               ref_req,
  input logic [ROW_W-1:0]   ref_row,
  input logic               pin_own,
  input logic               ras_n,
  input logic [NUM_CAS-1:0] cas_n
);
  localparam int unsigned PAUSE_CYC = CLK_KHZ / 5;
  localparam int unsigned SW = $clog2(PAUSE_CYC + 1);

  logic [SW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != SW'(PAUSE_CYC)) since_rst <= since_rst + 1'b1;
  end

  // R1
  pause_ras_high_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst < SW'(PAUSE_CYC)) |-> ras_n);

  // R2
  req_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> ready);

  // R3
  cbr_cas_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (($past(cas_n) & CAS_MASK) == '0) && ((cas_n & CAS_MASK) == '0));

  // R5
  rao_pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> (ras_n && (cas_n == '1) && !pin_own));

  // R5
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(ref_req && grant)) |=> $stable(ref_row));

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && grant) |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

  // R8
  err_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !ready);

endmodule

bind rfsh_sequencer rfsh_sequencer_chk #(
  .CLK_KHZ (CLK_KHZ),
  .ROW_W   (ROW_W),
  .NUM_CAS (NUM_CAS),
  .CAS_MASK(CAS_MASK)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .grant  (grant),
  .ready  (ready),
  .err    (err),
  .ref_req(ref_req),
  .ref_row(ref_row),
  .pin_own(pin_own),
  .ras_n  (ras_n),
  .cas_n  (cas_n)
);

// File: tb/rfsh_sequencer_bench.sv
module rfsh_sequencer_bench;
  localparam int PER      = 10;
  localparam int KHZ      = 2560;
  localparam int PAUSE    = KHZ / 5;
  localparam int IVAL     = KHZ / 64;
  localparam int WAKE     = 8;
  localparam int BLMAX    = 3;
  localparam int TSU      = 2;
  localparam int THD      = 2;
  localparam int TTL      = 3;
  localparam int TPR      = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rao_mode = 1'b0;
  logic grant = 1'b0;
  logic ready, err, ref_req, pin_own, ras_n;
  logic [9:0] ref_row;
  logic [1:0] cas_n;

  always #(PER/2) clk = ~clk;

  rfsh_sequencer #(
    .CLK_KHZ(KHZ), .WAKE_CYCLES(WAKE), .BACKLOG_MAX(BLMAX), .ROW_W(10),
    .NUM_CAS(2), .CAS_MASK(2'b11), .T_CAS_SETUP(TSU), .T_CAS_HOLD(THD),
    .T_RAS_TAIL(TTL), .T_RAS_PRE(TPR)
  ) u_rfsh_sequencer (
    .clk(clk), .rst(rst), .rao_mode(rao_mode), .grant(grant),
    .ready(ready), .err(err), .ref_req(ref_req), .ref_row(ref_row),
    .pin_own(pin_own), .ras_n(ras_n), .cas_n(cas_n)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard of expected refresh rows
  int exp_q[$];
  int exp_next = 0;

  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_next);
      exp_next = (exp_next + 1) % 1024;
    end
  endtask

  // monitor state
  int  since_rst, first_fall, falls_nr, falls_at_ready, window_falls;
  int  cas_low_run, ras_low_run, shape_chk;
  int  serves, run_cur, run_last, err_rises;
  bit  prev_ras, prev_ready, prev_err, seen_req, pins_bad, wrap_seen, ready_at_err;
  logic [1:0] prev_cas;

  always begin
    @(negedge clk);
    #(PER/4);
    if (rst) begin
      since_rst = 0; first_fall = -1; falls_nr = 0; falls_at_ready = -1;
      cas_low_run = 0; ras_low_run = 0; serves = 0; run_cur = 0; run_last = 0;
      err_rises = 0; prev_ras = 1'b1; prev_ready = 1'b0; prev_err = 1'b0;
      prev_cas = 2'b11; wrap_seen = 1'b0;
    end else begin
      since_rst++;
      if (prev_ras && !ras_n) begin
        falls_nr++;
        window_falls++;
        if (first_fall < 0) first_fall = since_rst;
        if (shape_chk < 30) begin
          shape_chk++;
          check(cas_low_run >= TSU, "R3 cas setup before ras fall", cas_low_run, TSU);
        end
      end
      if (!prev_ras && ras_n && shape_chk < 30)
        check(ras_low_run == THD + TTL, "R3 ras low width", ras_low_run, THD + TTL);
      if (prev_cas == 2'b00 && cas_n == 2'b11 && shape_chk < 30)
        check(!ras_n && ras_low_run == THD, "R3 cas hold after ras fall", ras_low_run, THD);
      cas_low_run = (cas_n == 2'b00) ? cas_low_run + 1 : 0;
      ras_low_run = (!ras_n) ? ras_low_run + 1 : 0;
      if (!prev_ready && ready) falls_at_ready = falls_nr;
      if (prev_ready && !ready) falls_nr = 0;
      if (!prev_err && err) begin
        err_rises++;
        ready_at_err = ready;
      end
      if (ref_req) seen_req = 1'b1;
      if (ref_req && (!ras_n || cas_n != 2'b11 || pin_own)) pins_bad = 1'b1;
      if (ref_req && grant) begin
        serves++;
        run_cur++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected grant", int'(ref_row), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(ref_row) == e, "R6 row order", int'(ref_row), e);
          if (e == 0 && serves > 1) wrap_seen = 1'b1;
        end
      end else begin
        if (run_cur > 0) run_last = run_cur;
        run_cur = 0;
      end
      prev_ras = ras_n; prev_ready = ready; prev_err = err; prev_cas = cas_n;
    end
  end

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit && !ready; i++) begin
      @(negedge clk);
      #(PER/4 + 1);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    #(PER/4 + 1);
    // R9 reset state
    check(ready == 1'b0, "R9 ready in reset", ready, 0);
    check(err == 1'b0 && ref_req == 1'b0, "R9 err/req in reset", {err, ref_req}, 0);
    check(ras_n == 1'b1 && cas_n == 2'b11, "R9 strobes in reset", {ras_n, cas_n}, 7);
    check(pin_own == 1'b1 && ref_row == 10'd0, "R9 pin_own/row in reset", int'(ref_row), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0, s0;
    shape_chk = 0;
    // ---------- CAS-before-RAS style ----------
    rao_mode = 1'b0;
    seen_req = 1'b0;
    pins_bad = 1'b0;
    do_reset();
    wait_ready(2000);
    check(first_fall >= PAUSE, "R1 pause before first ras fall", first_fall, PAUSE);
    check(falls_at_ready == WAKE, "R2 wake cycles before ready", falls_at_ready, WAKE);
    grant = 1'b1;
    window_falls = 0;
    repeat (10 * IVAL) @(negedge clk);
    #(PER/4 + 1);
    check(window_falls >= 9 && window_falls <= 11, "R4 refresh rate", window_falls, 10);
    check(!seen_req, "R4 no request in CBR style", seen_req, 0);
    check(ready && !err, "R4 still ready", {ready, err}, 2);
    grant = 1'b0;

    // ---------- row-address style ----------
    rao_mode = 1'b1;
    exp_q.delete();
    exp_next = 0;
    push_rows(1100);
    do_reset();
    seen_req = 1'b0;
    pins_bad = 1'b0;
    wait_ready(2000);
    check(falls_at_ready == WAKE, "R2 wake cycles before ready (row mode)", falls_at_ready, WAKE);
    @(negedge clk);
    grant = 1'b1;
    for (int i = 0; i < 50000 && serves < 1030; i++) @(negedge clk);
    #(PER/4 + 1);
    check(serves >= 1030, "R6 grants served", serves, 1030);
    check(wrap_seen, "R6 row wrap 1023 to 0", wrap_seen, 1);
    check(seen_req && !pins_bad, "R5 pins idle while requesting", pins_bad, 0);

    // withhold grants for exactly two intervals right after a serve
    for (int i = 0; i < 200 && !ref_req; i++) begin
      @(negedge clk);
      #(PER/4 + 1);
    end
    @(negedge clk);
    grant = 1'b0;
    #(PER/4 + 1);
    r0 = int'(ref_row);
    repeat (2 * IVAL - 1) @(negedge clk);
    #(PER/4 + 1);
    check(int'(ref_row) == r0, "R5 row holds without grant", int'(ref_row), r0);
    check(ref_req == 1'b1, "R5 request pending", ref_req, 1);
    @(negedge clk);
    run_last = 0;
    grant = 1'b1;
    repeat (10) @(negedge clk);
    #(PER/4 + 1);
    check(run_last == 2, "R7 back-to-back backlog burst", run_last, 2);
    check(!err, "R7 no overflow within limit", err, 0);

    // starve the handshake until the backlog overflows
    @(negedge clk);
    grant = 1'b0;
    for (int i = 0; i < 400 && !err; i++) begin
      @(negedge clk);
      #(PER/4 + 1);
    end
    check(err == 1'b1 && err_rises == 1, "R8 overflow raises err", err_rises, 1);
    check(ready_at_err == 1'b0, "R8 ready low at overflow", ready_at_err, 0);
    wait_ready(1000);
    check(falls_at_ready == WAKE, "R8 wake rerun count", falls_at_ready, WAKE);
    @(negedge clk);
    s0 = serves;
    grant = 1'b1;
    repeat (5 * IVAL) @(negedge clk);
    #(PER/4 + 1);
    check(serves > s0, "R8 refresh resumes after rerun", serves - s0, 4);
    check(err == 1'b1, "R8 err sticky", err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule